// File: doc/BRIEF.md
# Half-Baud Alternate Mark Inversion Line Codec

This block turns one direction of a serial bit stream into three-level line symbols and reads such symbols back. Each bit is started by a one-cycle strobe. A zero leaves the line at rest. A one puts a pulse on the line, and each pulse has the opposite polarity to the pulse before it. The pulse fills only the first half of the bit period, and the line is at rest for the second half. The line is carried on two wires: one for a positive pulse and one for a negative pulse. A phase output shows which half of the bit period is on the line.

For framing, the sender can ask for a deliberate code violation. This is a pulse with the same polarity as the pulse before it. When the balance enable is also set, the encoder adds one more bit period straight after the violation. That extra period carries a pulse of the opposite polarity, which cancels the DC offset the violation leaves behind. The decoder takes a sample strobe and the two received wires. For each sampled bit it reports the data bit and whether the pulse broke alternation. Each direction of a link uses its own copy of the block.

Top module: `ami_line_codec`

## Requirements
- R1: After reset, both line wires, `half_phase` and `rx_valid` are low. The first one sent after reset is a positive pulse (`line_pos` high).
- R2: A strobed zero with no violation request leaves both line wires low for the whole bit period. It does not change the polarity used for the next pulse.
- R3: A strobed one produces a pulse whose polarity is opposite to the last pulse sent. `line_pos` high means positive and `line_neg` high means negative.
- R4: A period accepted at clock edge E drives its pulse for the HALF_LEN cycles that follow E, with `half_phase` low. It then holds both wires low for the next HALF_LEN cycles, with `half_phase` high.
- R5: A strobe with `force_cv` high sends a pulse of the same polarity as the last pulse, whatever the value of `tx_bit`. The polarity memory is left as it was, so the next plain one is opposite to the violating pulse.
- R6: When `bal_en` is high together with `force_cv`, a second period follows the violation period with no gap and no strobe. It carries a pulse opposite to the violating pulse, and the next plain one is opposite to that balancing pulse.
- R7: Without `bal_en`, no extra period follows a violation. The line is idle (wires and `half_phase` low) once the period ends.
- R8: A strobe that arrives while a period is running, including a balancing period, is ignored. The current pulse and the period length do not change.
- R9: One cycle after a `rx_sample` strobe, `rx_valid` is high for one cycle. `rx_bit` is high exactly when one of the two received wires was high at the sample.
- R10: `rx_cv` is high when the sampled pulse has the same polarity as the previous sampled pulse. After reset, the decoder treats the last pulse as negative.
- R11: A sample with both received wires high is read as a zero with no violation, and it leaves the decoder polarity memory unchanged.
- R12: The encoder never drives both line wires high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_stb | input | 1 | One-cycle strobe that starts a bit period when the encoder is idle |
| tx_bit | input | 1 | Data bit captured with the strobe |
| force_cv | input | 1 | Send a same-polarity violation pulse for this bit |
| bal_en | input | 1 | Add a balancing period after the requested violation |
| line_pos | output | 1 | Positive pulse on the line |
| line_neg | output | 1 | Negative pulse on the line |
| half_phase | output | 1 | High during the rest half of a running bit period |
| rx_sample | input | 1 | Strobe that samples the received wires |
| rx_pos | input | 1 | Received positive pulse |
| rx_neg | input | 1 | Received negative pulse |
| rx_valid | output | 1 | Decoded bit available, one cycle |
| rx_bit | output | 1 | Decoded data bit |
| rx_cv | output | 1 | Decoded pulse broke alternation |

## Verification
The encoder assertions assume that `force_cv` and `bal_en` are only meaningful together with an accepted strobe, and that the line is only judged while a period is running or idle. The stimulus therefore changes these inputs only on strobe cycles and clears them right after. The strobes that land inside a running period are placed in the first half, so the rule that they are ignored is tested away from the period boundary. On the decoder side, the assertions assume that `rx_sample` falls in the pulse half of a bit. The bench raises it in the first cycle of each pulse when the line is looped back, and it drives the received wires directly only for the reset-memory and both-high cases.

// File: rtl/ami_pkg.sv
package ami_pkg;
  // Kind of symbol started in a bit period
  typedef enum logic [1:0] {
    SYM_SPACE = 2'd0,
    SYM_MARK  = 2'd1,
    SYM_VIOL  = 2'd2,
    SYM_BAL   = 2'd3
  } sym_kind_t;

  // Two-wire line symbol
  typedef struct packed {
    logic pos;
    logic neg;
  } line_sym_t;
endpackage

// File: rtl/ami_period_timer.sv
module ami_period_timer #(
  parameter int HALF_LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active,
  output logic at_mid,
  output logic at_end
);
  localparam int PERIOD = 2 * HALF_LEN;
  localparam int CW     = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] MID_V  = CW'(HALF_LEN - 1);
  localparam logic [CW-1:0] LAST_V = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;

  assign active = act_q;
  assign at_mid = act_q && (cnt_q == MID_V);
  assign at_end = act_q && (cnt_q == LAST_V);

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (start) begin
      cnt_d = '0;
      act_d = 1'b1;
    end else if (at_end) begin
      cnt_d = '0;
      act_d = 1'b0;
    end else if (act_q) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  // R4: a running period may not be cut short before its last cycle
  assert_period_runs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !at_end) |=> act_q);
endmodule

// File: rtl/ami_encoder.sv
module ami_encoder
  import ami_pkg::*;
#(
  parameter int HALF_LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic tx_bit,
  input  logic force_cv,
  input  logic bal_en,
  output logic line_pos,
  output logic line_neg,
  output logic half_phase
);
  logic active, at_mid, at_end;
  logic accept, bal_start, start;

  // polarity of the last pulse sent: 1 = positive
  logic last_pos_q, last_pos_d;
  logic bal_pend_q, bal_pend_d;
  line_sym_t sym_q, sym_d;
  logic half_q, half_d;
  sym_kind_t kind;
  logic pulse_pos;

  assign accept    = bit_stb && !active;
  assign bal_start = at_end && bal_pend_q;
  assign start     = accept || bal_start;

  ami_period_timer #(.HALF_LEN(HALF_LEN)) i_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .active (active),
    .at_mid (at_mid),
    .at_end (at_end)
  );

  // Pick the symbol of a period that starts this cycle
  always_comb begin
    if (bal_start)        kind = SYM_BAL;
    else if (force_cv)    kind = SYM_VIOL;
    else if (tx_bit)      kind = SYM_MARK;
    else                  kind = SYM_SPACE;
  end

  always_comb begin
    last_pos_d = last_pos_q;
    pulse_pos  = !last_pos_q;
    if (start) begin
      unique case (kind)
        SYM_VIOL:  pulse_pos = last_pos_q;
        SYM_MARK,
        SYM_BAL:   last_pos_d = !last_pos_q;
        default:   pulse_pos = !last_pos_q;
      endcase
    end
  end

  always_comb begin
    bal_pend_d = bal_pend_q;
    if (accept)         bal_pend_d = force_cv && bal_en;
    else if (bal_start) bal_pend_d = 1'b0;
  end

  always_comb begin
    sym_d  = sym_q;
    half_d = half_q;
    if (start) begin
      sym_d.pos = (kind != SYM_SPACE) && pulse_pos;
      sym_d.neg = (kind != SYM_SPACE) && !pulse_pos;
      half_d    = 1'b0;
    end else if (at_mid) begin
      sym_d  = '0;
      half_d = 1'b1;
    end else if (at_end) begin
      sym_d  = '0;
      half_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_pos_q <= 1'b0;
      bal_pend_q <= 1'b0;
      sym_q      <= '0;
      half_q     <= 1'b0;
    end else begin
      last_pos_q <= last_pos_d;
      bal_pend_q <= bal_pend_d;
      sym_q      <= sym_d;
      half_q     <= half_d;
    end
  end

  assign line_pos   = sym_q.pos;
  assign line_neg   = sym_q.neg;
  assign half_phase = half_q;

  assert_wires_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_pos && line_neg));

  assert_rest_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
    half_phase |-> (!line_pos && !line_neg));

  assert_cv_same_pol_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && force_cv) |=> (line_pos == $past(last_pos_q)) && (line_neg == !$past(last_pos_q)));

  assert_bal_opposite_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bal_start |=> (line_pos == !$past(last_pos_q)) && (line_neg == $past(last_pos_q)));

  assert_busy_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && active && !at_end) |=> $stable(last_pos_q));
endmodule

// File: rtl/ami_decoder.sv
module ami_decoder (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_sample,
  input  logic rx_pos,
  input  logic rx_neg,
  output logic rx_valid,
  output logic rx_bit,
  output logic rx_cv
);
  logic mark, pos_only;
  logic last_pos_q, last_pos_d;
  logic valid_q, valid_d;
  logic bit_q, bit_d;
  logic cv_q, cv_d;

  // both wires high is treated as no pulse
  assign mark     = rx_pos ^ rx_neg;
  assign pos_only = rx_pos && !rx_neg;

  always_comb begin
    last_pos_d = last_pos_q;
    valid_d    = rx_sample;
    bit_d      = bit_q;
    cv_d       = cv_q;
    if (rx_sample) begin
      bit_d = mark;
      cv_d  = mark && (pos_only == last_pos_q);
      if (mark) last_pos_d = pos_only;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_pos_q <= 1'b0;
      valid_q    <= 1'b0;
      bit_q      <= 1'b0;
      cv_q       <= 1'b0;
    end else begin
      last_pos_q <= last_pos_d;
      valid_q    <= valid_d;
      bit_q      <= bit_d;
      cv_q       <= cv_d;
    end
  end

  assign rx_valid = valid_q;
  assign rx_bit   = bit_q;
  assign rx_cv    = cv_q;

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(rx_sample));

  assert_both_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_sample && rx_pos && rx_neg) |=> (!rx_bit && !rx_cv && $stable(last_pos_q)));

  assert_cv_needs_mark_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cv |-> rx_bit);
endmodule

// File: rtl/ami_line_codec.sv
module ami_line_codec #(
  parameter int HALF_LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic tx_bit,
  input  logic force_cv,
  input  logic bal_en,
  output logic line_pos,
  output logic line_neg,
  output logic half_phase,
  input  logic rx_sample,
  input  logic rx_pos,
  input  logic rx_neg,
  output logic rx_valid,
  output logic rx_bit,
  output logic rx_cv
);
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  ami_encoder #(.HALF_LEN(HALF_LEN)) i_enc (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .bit_stb    (bit_stb),
    .tx_bit     (tx_bit),
    .force_cv   (force_cv),
    .bal_en     (bal_en),
    .line_pos   (line_pos),
    .line_neg   (line_neg),
    .half_phase (half_phase)
  );

  ami_decoder i_dec (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .rx_sample (rx_sample),
    .rx_pos    (rx_pos),
    .rx_neg    (rx_neg),
    .rx_valid  (rx_valid),
    .rx_bit    (rx_bit),
    .rx_cv     (rx_cv)
  );

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(rst_n_int) |-> (!line_pos && !line_neg && !half_phase && !rx_valid));
endmodule

// File: tb/test_ami_line_codec.sv
module test_ami_line_codec;
  localparam int H = 2;

  logic clk, rst_n;
  logic bit_stb, tx_bit, force_cv, bal_en;
  logic line_pos, line_neg, half_phase;
  logic rx_sample, rx_pos, rx_neg, rx_valid, rx_bit, rx_cv;
  logic lb, drv_pos, drv_neg;

  int checks, errors;
  bit done;
  bit exp_last;   // encoder: last pulse positive
  bit dec_last;   // decoder: last pulse positive
  bit exp_dbit, exp_dcv;

  assign rx_pos = lb ? line_pos : drv_pos;
  assign rx_neg = lb ? line_neg : drv_neg;

  ami_line_codec #(.HALF_LEN(H)) i_ami_line_codec (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .tx_bit(tx_bit),
    .force_cv(force_cv), .bal_en(bal_en), .line_pos(line_pos),
    .line_neg(line_neg), .half_phase(half_phase), .rx_sample(rx_sample),
    .rx_pos(rx_pos), .rx_neg(rx_neg), .rx_valid(rx_valid),
    .rx_bit(rx_bit), .rx_cv(rx_cv)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Called just before the edge that starts the period
  task automatic check_period(input bit mark, input bit pol, input bit mid, input string req);
    bit ep, en;
    for (int k = 0; k < 2*H; k++) begin
      @(negedge clk);
      if (k == 0) begin
        bit_stb = 0; tx_bit = 0; force_cv = 0; bal_en = 0;
        rx_sample = 1;
        exp_dbit = mark;
        exp_dcv  = mark && (pol == dec_last);
        if (mark) dec_last = pol;
      end
      if (k == 1) begin
        rx_sample = 0;
        if (mid) begin bit_stb = 1; tx_bit = 1; end
        check(rx_valid == 1'b1, "R9", rx_valid, 1);
        check(rx_bit == exp_dbit, "R9", rx_bit, exp_dbit);
        check(rx_cv == exp_dcv, "R10", rx_cv, exp_dcv);
      end
      if (k == 2) begin
        bit_stb = 0; tx_bit = 0;
        check(rx_valid == 1'b0, "R9", rx_valid, 0);
      end
      ep = (k < H) && mark && pol;
      en = (k < H) && mark && !pol;
      check(line_pos == ep, mid ? "R8" : req, line_pos, ep);
      check(line_neg == en, mid ? "R8" : req, line_neg, en);
      check(half_phase == (k >= H), "R4", half_phase, (k >= H));
      check(!(line_pos && line_neg), "R12", {line_pos, line_neg}, 0);
    end
  endtask

  // kind: 0 zero, 1 one, 2 violation, 3 violation with balance
  task automatic send_sym(input int kind, input bit mid, input string req);
    bit mark, pol;
    @(negedge clk);
    bit_stb = 1;
    tx_bit = (kind == 1) || (kind >= 2 && mid);
    force_cv = (kind >= 2);
    bal_en = (kind == 3);
    case (kind)
      0: begin mark = 0; pol = !exp_last; end
      1: begin mark = 1; pol = !exp_last; exp_last = pol; end
      default: begin mark = 1; pol = exp_last; end
    endcase
    check_period(mark, pol, mid, req);
    if (kind == 3) begin
      pol = !exp_last;
      exp_last = pol;
      check_period(1'b1, pol, 1'b0, "R6");
    end
    @(negedge clk);
    check(!line_pos && !line_neg && !half_phase, (kind == 2) ? "R7" : "R4",
          {line_pos, line_neg, half_phase}, 0);
  endtask

  task automatic dec_probe(input bit p, input bit n, input bit eb, input bit ec, input string req);
    @(negedge clk);
    drv_pos = p; drv_neg = n; rx_sample = 1;
    @(negedge clk);
    rx_sample = 0;
    check(rx_valid == 1'b1, "R9", rx_valid, 1);
    check(rx_bit == eb, req, rx_bit, eb);
    check(rx_cv == ec, req, rx_cv, ec);
    drv_pos = 0; drv_neg = 0;
  endtask

  initial begin
    checks = 0; errors = 0; done = 0;
    bit_stb = 0; tx_bit = 0; force_cv = 0; bal_en = 0;
    rx_sample = 0; lb = 0; drv_pos = 0; drv_neg = 0;
    exp_last = 0; dec_last = 0;
    rst_n = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) @(negedge clk);
    check(!line_pos && !line_neg && !half_phase && !rx_valid, "R1",
          {line_pos, line_neg, half_phase, rx_valid}, 0);

    // decoder driven directly: reset memory, both-high handling
    dec_probe(0, 1, 1, 1, "R10");
    dec_probe(1, 1, 0, 0, "R11");
    dec_probe(0, 1, 1, 1, "R11");
    dec_probe(1, 0, 1, 0, "R10");
    dec_probe(0, 1, 1, 0, "R10");
    dec_last = 0;

    lb = 1;
    send_sym(1, 0, "R1");
    send_sym(0, 0, "R2");
    send_sym(1, 0, "R3");
    send_sym(2, 0, "R5");
    send_sym(1, 0, "R5");
    send_sym(3, 1, "R6");
    send_sym(1, 0, "R6");

    // sweep of all three-symbol sequences
    for (int p = 0; p < 64; p++) begin
      for (int s = 0; s < 3; s++) begin
        int kind;
        string req;
        kind = (p >> (2*s)) & 3;
        case (kind)
          0: req = "R2";
          1: req = "R3";
          2: req = "R5";
          default: req = "R6";
        endcase
        send_sym(kind, ((p + s) % 3) == 0, req);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule